// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host processor and a display controller. The host can use either of two bus styles. In the strobe-pair style, separate active-low read and write strobes mark each access. In the enable style, an active-high enable strobe marks the access and a direction line chooses read or write. A static mode input selects the style, and the two style-dependent pins are shared between them. Chip select, the A0 address line and the strobes are decoded into four transaction kinds: status read, data read, data/parameter write and command write.

The host control pins are brought into the internal clock domain through a synchronizer. Each finished access produces exactly one single-cycle transaction pulse, together with its kind and the captured write byte. The host never waits: there is no ready or wait signal. Read data goes straight onto the data bus while the read is open. A status read returns a live retrace flag on bit 6. While the controller is asleep, command writes are dropped unless the code is the wake code or the sleep code.

Top module: `hostbus_frontend`

## Requirements
- R1: While reset is held low, and on release, `txn_valid` is 0 and `data_oe` is 0.
- R2: With `bus_mode`=0, an access with `cs_n`=0, `rd_e`=0 and `wr_rw`=1 is a read. It yields one `txn_valid` pulse after `rd_e` rises. `txn_kind` is 0 (status read) for A0=0 and 1 (data read) for A0=1.
- R3: With `bus_mode`=0, an access with `cs_n`=0, `wr_rw`=0 and `rd_e`=1 is a write. It yields one pulse after `wr_rw` rises. `txn_kind` is 2 (data/parameter write) for A0=0 and 3 (command write) for A0=1. `txn_data` holds the byte present on `data_in` during the strobe.
- R4: With `bus_mode`=1 and `wr_rw`=1, a high pulse on `rd_e` with `cs_n`=0 is a read. It yields one pulse after `rd_e` falls, with `txn_kind` 0 for A0=0 and 1 for A0=1.
- R5: With `bus_mode`=1 and `wr_rw`=0, a high pulse on `rd_e` with `cs_n`=0 is a write. `txn_kind` is 2 for A0=0 and 3 for A0=1, and `txn_data` holds the written byte.
- R6: During a status read, `data_out` bit 6 follows `retrace` live, and all other bits are 0.
- R7: During a data read, `data_out` equals `rd_data`.
- R8: `data_oe` is 0 whenever `cs_n` is 1 or no read strobe is active. In particular, it is 0 during writes.
- R9: While `sleep_mode` is 1, a command write is passed on only if its code is `CMD_WAKE` (0x40) or `CMD_SLEEP` (0x53). Any other command write gives no pulse. Data writes still pass.
- R10: `txn_valid` is never high on two consecutive cycles, and each access gives exactly one pulse.
- R11: Strobe activity while `cs_n` is 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode | input | 1 | 0 strobe-pair style, 1 enable style |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Address line: 0 status/data, 1 data read/command |
| rd_e | input | 1 | Read strobe (mode 0, active low) or enable (mode 1, active high) |
| wr_rw | input | 1 | Write strobe (mode 0, active low) or direction, 1 = read (mode 1) |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Drive enable for the data bus |
| retrace | input | 1 | Display retrace flag from the timing logic |
| sleep_mode | input | 1 | Controller is asleep |
| rd_data | input | 8 | Next read byte from the memory side |
| txn_valid | output | 1 | One-cycle transaction pulse |
| txn_kind | output | 2 | Transaction kind, encoded as in R2 to R5 |
| txn_data | output | 8 | Captured write byte |

## Verification
Two things can meet in one cycle. The retrace flag can change while a status read strobe is open, and the sleep input can be set while a command write completes. The bench toggles `retrace` in the middle of a held status read and checks that bit 6 follows within the same strobe. It then issues command writes with sleep asserted, using a rejected code and both accepted codes, and compares the pulse count and `txn_data` against the R9 rule.

// File: rtl/hostbus_frontend.sv
module hostbus_frontend #(
  parameter int DW = 8,
  parameter int STAT_BIT = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] CMD_WAKE = 8'h40,
  parameter logic [DW-1:0] CMD_SLEEP = 8'h53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          rd_e,
  input  logic          wr_rw,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          retrace,
  input  logic          sleep_mode,
  input  logic [DW-1:0] rd_data,
  output logic          txn_valid,
  output logic [1:0]    txn_kind,
  output logic [DW-1:0] txn_data
);
  localparam int BW = DW + 4;
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [BW-1:0] IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [BW-1:0] sync_q [SYNC_STAGES];
  logic [BW-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE;
      prev_q <= IDLE;
    end else begin
      sync_q[0] <= {cs_n, a0, rd_e, wr_rw, data_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  logic          old_cs_n, old_a0, old_rd, old_wr, cur_rd, cur_wr;
  logic [DW-1:0] old_data;
  assign {old_cs_n, old_a0, old_rd, old_wr, old_data} = prev_q;
  assign cur_rd = sync_q[LAST][DW+1];
  assign cur_wr = sync_q[LAST][DW];

  logic acc_end, acc_read;
  always_comb begin
    if (!bus_mode) begin
      acc_read = old_wr;
      acc_end  = !old_cs_n && ((!old_rd && cur_rd && old_wr) ||
                               (!old_wr && cur_wr && old_rd));
    end else begin
      acc_read = old_wr;
      acc_end  = !old_cs_n && old_rd && !cur_rd;
    end
  end

  logic [1:0] kind_d;
  logic       cmd_blocked;
  assign kind_d = {!acc_read, old_a0};
  assign cmd_blocked = sleep_mode && (kind_d == 2'd3) &&
                       (old_data != CMD_WAKE) && (old_data != CMD_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_valid <= 1'b0;
      txn_kind  <= 2'd0;
      txn_data  <= '0;
    end else begin
      txn_valid <= acc_end && !cmd_blocked;
      if (acc_end) begin
        txn_kind <= kind_d;
        txn_data <= old_data;
      end
    end
  end

  logic [DW-1:0] status_byte;
  always_comb begin
    status_byte = '0;
    status_byte[STAT_BIT] = retrace;
  end

  assign data_oe  = !cs_n && (bus_mode ? (rd_e && wr_rw) : (!rd_e && wr_rw));
  assign data_out = !data_oe ? '0 : (a0 ? rd_data : status_byte);
endmodule

// File: rtl/hostbus_frontend_chk.sv
module hostbus_frontend_chk #(
  parameter int DW = 8,
  parameter int STAT_BIT = 6,
  parameter logic [DW-1:0] CMD_WAKE = 8'h40,
  parameter logic [DW-1:0] CMD_SLEEP = 8'h53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_mode,
  input logic          cs_n,
  input logic          a0,
  input logic          rd_e,
  input logic          wr_rw,
  input logic          retrace,
  input logic          sleep_mode,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic          txn_valid,
  input logic [1:0]    txn_kind,
  input logic [DW-1:0] txn_data
);
  logic [DW-1:0] other_mask;
  always_comb begin
    other_mask = '1;
    other_mask[STAT_BIT] = 1'b0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!txn_valid && !data_oe));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> !txn_valid);
  a_r8_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !data_oe);
  a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && !wr_rw) |-> !data_oe);
  a_r6_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !a0) |-> (data_out[STAT_BIT] == retrace && (data_out & other_mask) == '0));
  a_r7_data_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && a0) |-> data_out == rd_data);
  a_r9_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_kind == 2'd3 && $past(sleep_mode)) |->
      (txn_data == CMD_WAKE || txn_data == CMD_SLEEP));
endmodule

bind hostbus_frontend hostbus_frontend_chk #(
  .DW(DW), .STAT_BIT(STAT_BIT), .CMD_WAKE(CMD_WAKE), .CMD_SLEEP(CMD_SLEEP)
) chk (
  .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
  .rd_e(rd_e), .wr_rw(wr_rw), .retrace(retrace), .sleep_mode(sleep_mode),
  .rd_data(rd_data), .data_out(data_out), .data_oe(data_oe),
  .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_data(txn_data)
);

// File: tb/hostbus_frontend_test.sv
module hostbus_frontend_test;
  logic clk = 0, rst_n = 0, bus_mode = 0, cs_n = 1, a0 = 0, rd_e = 1, wr_rw = 1;
  logic retrace = 0, sleep_mode = 0;
  logic [7:0] data_in = 0, rd_data = 8'hA5;
  logic [7:0] data_out;
  logic data_oe, txn_valid;
  logic [1:0] txn_kind;
  logic [7:0] txn_data;
  int checks = 0, failures = 0, pulses = 0, doubles = 0;
  logic [1:0] last_kind;
  logic [7:0] last_data;
  logic prev_v = 0;

  always #10 clk = ~clk;

  hostbus_frontend uut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
    .rd_e(rd_e), .wr_rw(wr_rw), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .retrace(retrace), .sleep_mode(sleep_mode),
    .rd_data(rd_data), .txn_valid(txn_valid), .txn_kind(txn_kind),
    .txn_data(txn_data)
  );

  always @(negedge clk) begin
    if (txn_valid) begin
      pulses++;
      last_kind = txn_kind;
      last_data = txn_data;
      if (prev_v) doubles++;
    end
    prev_v = txn_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    cyc(1);
    @(negedge clk);
  endtask

  task automatic access(input bit rd, input bit a, input logic [7:0] d, input bit sel,
                        output int got, output bit oe_seen, output logic [7:0] bus_seen);
    int p0;
    p0 = pulses;
    cyc(1);
    cs_n = !sel; a0 = a; data_in = d;
    if (bus_mode) wr_rw = rd;
    cyc(2);
    if (bus_mode) rd_e = 1;
    else if (rd) rd_e = 0;
    else wr_rw = 0;
    cyc(3);
    @(negedge clk);
    oe_seen = data_oe; bus_seen = data_out;
    cyc(1);
    if (bus_mode) rd_e = 0;
    else begin rd_e = 1; wr_rw = 1; end
    cyc(6);
    cs_n = 1;
    if (bus_mode) wr_rw = 1;
    cyc(2);
    @(negedge clk);
    got = pulses - p0;
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 0; bus_mode = mode; cs_n = 1;
    rd_e = !mode; wr_rw = 1;
    cyc(3);
    @(negedge clk);
    check(!txn_valid && !data_oe, "R1", {txn_valid, data_oe}, 0);
    rst_n = 1;
    cyc(4);
    @(negedge clk);
    check(pulses == 0 || !txn_valid, "R1", txn_valid, 0);
    check(!data_oe, "R1", data_oe, 0);
  endtask

  task automatic t_strobe_reads();
    int n; bit oe; logic [7:0] b;
    retrace = 1;
    access(1, 0, 8'h00, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd0, "R2", {n[7:0], 6'd0, last_kind}, 16'h0100);
    check(oe && b == 8'h40, "R6", {oe, b}, 9'h140);
    rd_data = 8'h3C;
    access(1, 1, 8'h00, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd1, "R2", {n[7:0], 6'd0, last_kind}, 16'h0101);
    check(oe && b == 8'h3C, "R7", {oe, b}, 9'h13C);
  endtask

  task automatic t_retrace_live();
    cyc(1);
    cs_n = 0; a0 = 0; retrace = 1;
    cyc(2); rd_e = 0; cyc(1);
    @(negedge clk);
    check(data_out == 8'h40, "R6", data_out, 8'h40);
    retrace = 0;
    #1;
    check(data_out == 8'h00 && data_oe, "R6", data_out, 8'h00);
    cyc(1); rd_e = 1; cyc(5); cs_n = 1; cyc(2);
  endtask

  task automatic t_strobe_writes();
    int n; bit oe; logic [7:0] b;
    access(0, 0, 8'h5A, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd2 && last_data == 8'h5A, "R3",
          {n[7:0], 6'd0, last_kind, last_data}, 24'h01025A);
    check(!oe, "R8", oe, 0);
    access(0, 1, 8'hC3, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd3 && last_data == 8'hC3, "R3",
          {n[7:0], 6'd0, last_kind, last_data}, 24'h0103C3);
  endtask

  task automatic t_deselected();
    int n; bit oe; logic [7:0] b;
    access(1, 0, 8'h00, 0, n, oe, b);
    check(n == 0, "R11", n, 0);
    check(!oe, "R8", oe, 0);
    access(0, 1, 8'h77, 0, n, oe, b);
    check(n == 0, "R11", n, 0);
  endtask

  task automatic t_enable_reads();
    int n; bit oe; logic [7:0] b;
    retrace = 0;
    access(1, 0, 8'h00, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd0, "R4", {n[7:0], 6'd0, last_kind}, 16'h0100);
    check(oe && b == 8'h00, "R6", {oe, b}, 9'h100);
    rd_data = 8'hE1;
    access(1, 1, 8'h00, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd1, "R4", {n[7:0], 6'd0, last_kind}, 16'h0101);
    check(oe && b == 8'hE1, "R7", {oe, b}, 9'h1E1);
  endtask

  task automatic t_enable_writes();
    int n; bit oe; logic [7:0] b;
    access(0, 0, 8'h19, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd2 && last_data == 8'h19, "R5",
          {n[7:0], 6'd0, last_kind, last_data}, 24'h010219);
    check(!oe, "R8", oe, 0);
    access(0, 1, 8'h8E, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd3 && last_data == 8'h8E, "R5",
          {n[7:0], 6'd0, last_kind, last_data}, 24'h01038E);
  endtask

  task automatic t_sleep();
    int n; bit oe; logic [7:0] b;
    sleep_mode = 1;
    access(0, 1, 8'h12, 1, n, oe, b);
    check(n == 0, "R9", n, 0);
    access(0, 1, 8'h40, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd3 && last_data == 8'h40, "R9",
          {n[7:0], last_data}, 16'h0140);
    access(0, 1, 8'h53, 1, n, oe, b);
    check(n == 1 && last_data == 8'h53, "R9", {n[7:0], last_data}, 16'h0153);
    access(0, 0, 8'h12, 1, n, oe, b);
    check(n == 1 && last_kind == 2'd2 && last_data == 8'h12, "R9",
          {n[7:0], last_data}, 16'h0112);
    sleep_mode = 0;
    access(0, 1, 8'h12, 1, n, oe, b);
    check(n == 1 && last_data == 8'h12, "R9", {n[7:0], last_data}, 16'h0112);
  endtask

  initial begin : watchdog
    #3000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(0);
    t_strobe_reads();
    t_retrace_live();
    t_strobe_writes();
    t_deselected();
    do_reset(1);
    t_enable_reads();
    t_enable_writes();
    t_deselected();
    t_sleep();
    check(doubles == 0, "R10", doubles, 0);
    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule